// File: doc/BRIEF.md
# Dual-Mode Tick and Edge Counter

This block is a 16-bit counter with a compare flag. It counts in one of two ways. In time mode it counts ticks from an internal prescaler that divides the system clock. In edge mode it counts qualifying edges on an external input. That input is synchronized first, and a polarity bit chooses whether rising or falling edges count. When the count reaches a programmed compare value, a sticky flag is set. A configuration bit decides whether the counter then returns to zero or keeps running until it wraps past its maximum value.

Software controls the block through four word-wide registers, using a one-cycle write strobe and a registered read path.

Address map:

| Address | Register | Notes |
|---|---|---|
| 0 | Control | Described below |
| 1 | Prescaler | Bits 3:0 hold the divide code N; bit 4 bypasses the prescaler |
| 2 | Compare | 16-bit compare value |
| 3 | Count | Current count; read-only |

Control register bits:

| Bit | Function |
|---|---|
| 0 | Run: enables the block |
| 1 | Source: 0 = time mode, 1 = edge mode |
| 2 | Edge polarity |
| 3 | Free-run |
| 4 | Interrupt enable |
| 5 | Match flag: reads the flag; writing 1 clears it |

Clearing the run bit holds the counter, the flag and the prescaler in reset.

Top module: `ptc_top`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: Time mode with the prescaler bypassed (prescaler bit 4 = 1): the count rises by one on every clock edge after the edge that sets the run bit.
- R3: Time mode with bypass clear and code N: the count rises by one every 2^(N+1) clocks. For N = 1, the first increment comes on the 4th edge after the enabling edge.
- R4: Edge mode (control bit 1 = 1) with polarity 0: each rising edge of `pulse_in` gives exactly one increment, and falling edges give none.
- R5: Edge mode with polarity 1: each falling edge of `pulse_in` gives exactly one increment, and rising edges give none.
- R6: With free-run clear, an increment taken while the count equals the compare value loads zero into the count and sets the match flag. The count therefore cycles through compare+1 values.
- R7: With free-run set, an increment taken at the compare value sets the flag and the count still advances. The count wraps from 0xFFFF to 0.
- R8: The match flag stays set until a control write with bit 5 = 1, which clears it. If a new match lands in the same cycle as the clear, the new match wins.
- R9: `irq_o` goes high one clock after the flag and interrupt enable are both set. It goes low one clock after either of them clears.
- R10: One clock after the run bit goes low, the count and the flag read zero.
- R11: The source, polarity and free-run bits, and the prescaler register, change only on a write that finds the block stopped and that leaves the run bit 0. Writes made while the block runs, and writes that set the run bit, leave them unchanged. The interrupt enable and the compare value accept writes at any time.
- R12: Reading any register, including the count, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Registered read data; reflects `rd_addr` one edge later |
| pulse_in | input | 1 | External edge source, asynchronous |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A count that stops clearing on disable, or a flag that gets lost, shows at the next count or control read, within one clock of the event. A prescaler that divides by the wrong power of two shows up within a few periods as a count that is off by one or more at a fixed delay after enable.

A synchronizer that misses an edge, or counts one twice, leaves a count different from the number of pulses driven. A lock on the configuration bits that leaks shows as changed control bits on the read that follows the write. The interrupt output lags the flag by exactly one clock, so a wrong gating appears on the next edge.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_PRESC = 2'd1;
  localparam logic [ADDR_W-1:0] A_CMP   = 2'd2;
  localparam logic [ADDR_W-1:0] A_COUNT = 2'd3;

  localparam int B_RUN  = 0;
  localparam int B_SRC  = 1;
  localparam int B_POL  = 2;
  localparam int B_FREE = 3;
  localparam int B_IE   = 4;
  localparam int B_FLAG = 5;

  localparam int B_BYP  = 4;

  typedef struct packed {
    logic src;
    logic pol;
    logic free;
  } lock_cfg_t;
endpackage

// File: rtl/ptc_prescaler.sv
module ptc_prescaler #(
  parameter int PS_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            byp,
  input  logic [PS_W-1:0] code,
  output logic            tick
);
  localparam int DIV_W = 2 ** PS_W;

  logic [DIV_W-1:0] pcnt;
  logic [DIV_W:0]   span;
  logic [DIV_W-1:0] last;
  logic [PS_W:0]    shamt;

  always_comb begin
    shamt = {1'b0, code} + 1'b1;
    span  = (DIV_W + 1)'(1) << shamt;
    last  = DIV_W'(span - 1'b1);
  end

  assign tick = en && (byp || (pcnt == last));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pcnt <= '0;
    end else if (pcnt == last) begin
      pcnt <= '0;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/ptc_edge_sync.sv
module ptc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= din;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= 1'b0;
      else     chain[g] <= chain[g-1];
    end
  end

  assign rise =  chain[STAGES-1] && !chain[STAGES];
  assign fall = !chain[STAGES-1] &&  chain[STAGES];
endmodule

// File: rtl/ptc_count_core.sv
module ptc_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             inc,
  input  logic             free,
  input  logic             clr,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt,
  output logic             flag
);
  logic hit;

  assign hit = inc && (cnt == cmp);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      if (inc) begin
        if (hit && !free) cnt <= '0;
        else              cnt <= cnt + 1'b1;
      end
      flag <= hit || (flag && !clr);
    end
  end
endmodule

// File: rtl/ptc_top.sv
module ptc_top #(
  parameter int CNT_W   = 16,
  parameter int PS_W    = 4,
  parameter int SYNC_N  = 2,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              pulse_in,
  output logic              irq_o
);
  import ptc_pkg::*;

  logic             en_q, ie_q, byp_q;
  lock_cfg_t        cfg_q;
  logic [PS_W-1:0]  code_q;
  logic [CNT_W-1:0] cmp_q, cnt_q;
  logic             flag_q;
  logic             wr_ctrl, wr_presc, cfg_open, clr_flag;
  logic             tick, rise, fall, edge_ev, inc;
  logic [DATA_W-1:0] rd_mux;

  assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
  assign wr_presc = wr_en && (wr_addr == A_PRESC) && !en_q;
  assign cfg_open = wr_ctrl && !en_q && !wr_data[B_RUN];
  assign clr_flag = wr_ctrl && wr_data[B_FLAG];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      cfg_q  <= '0;
      byp_q  <= 1'b0;
      code_q <= '0;
      cmp_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q <= wr_data[B_RUN];
        ie_q <= wr_data[B_IE];
      end
      if (cfg_open) begin
        cfg_q.src  <= wr_data[B_SRC];
        cfg_q.pol  <= wr_data[B_POL];
        cfg_q.free <= wr_data[B_FREE];
      end
      if (wr_presc) begin
        code_q <= wr_data[PS_W-1:0];
        byp_q  <= wr_data[B_BYP];
      end
      if (wr_en && (wr_addr == A_CMP)) cmp_q <= wr_data[CNT_W-1:0];
    end
  end

  ptc_prescaler #(.PS_W(PS_W)) presc_i (
    .clk(clk), .rst(rst), .en(en_q), .byp(byp_q), .code(code_q), .tick(tick)
  );

  ptc_edge_sync #(.STAGES(SYNC_N)) sync_i (
    .clk(clk), .rst(rst), .din(pulse_in), .rise(rise), .fall(fall)
  );

  assign edge_ev = cfg_q.pol ? fall : rise;
  assign inc     = cfg_q.src ? edge_ev : tick;

  ptc_count_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst(rst), .en(en_q), .inc(inc), .free(cfg_q.free),
    .clr(clr_flag), .cmp(cmp_q), .cnt(cnt_q), .flag(flag_q)
  );

  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      A_CTRL: begin
        rd_mux[B_RUN]  = en_q;
        rd_mux[B_SRC]  = cfg_q.src;
        rd_mux[B_POL]  = cfg_q.pol;
        rd_mux[B_FREE] = cfg_q.free;
        rd_mux[B_IE]   = ie_q;
        rd_mux[B_FLAG] = flag_q;
      end
      A_PRESC: begin
        rd_mux[PS_W-1:0] = code_q;
        rd_mux[B_BYP]    = byp_q;
      end
      A_CMP:   rd_mux[CNT_W-1:0] = cmp_q;
      default: rd_mux[CNT_W-1:0] = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq_o   <= 1'b0;
    end else begin
      rd_data <= rd_mux;
      irq_o   <= flag_q && ie_q;
    end
  end
endmodule

// File: rtl/ptc_chk.sv
module ptc_chk #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              en_q,
  input logic              ie_q,
  input logic              src_q,
  input logic              pol_q,
  input logic              free_q,
  input logic              flag_q,
  input logic              inc,
  input logic              wr_ctrl,
  input logic [DATA_W-1:0] wr_data,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  cmp_q,
  input logic              irq_o
);
  // R10
  dis_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> (cnt_q == '0 && !flag_q));

  // R6
  cmp_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q && inc && !free_q && cnt_q == cmp_q) |=> (cnt_q == '0 && flag_q));

  // R7
  free_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q && inc && free_q) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q && flag_q && !(wr_ctrl && wr_data[5])) |=> flag_q);

  // R11
  cfg_lock_chk: assert property (@(posedge clk) disable iff (rst)
    en_q |=> ($stable(src_q) && $stable(pol_q) && $stable(free_q)));

  // R9
  irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (!flag_q || !ie_q) |=> !irq_o);

  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(flag_q && ie_q));
endmodule

bind ptc_top ptc_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .en_q(en_q), .ie_q(ie_q), .src_q(cfg_q.src),
  .pol_q(cfg_q.pol), .free_q(cfg_q.free), .flag_q(flag_q), .inc(inc),
  .wr_ctrl(wr_ctrl), .wr_data(wr_data), .cnt_q(cnt_q), .cmp_q(cmp_q),
  .irq_o(irq_o)
);

// File: tb/ptc_top_tb_top.sv
module ptc_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        pulse_in = 1'b0;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit sample_due = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #5 clk = ~clk;

  ptc_top dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pulse_in(pulse_in), .irq_o(irq_o)
  );

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // monitor: pops the expected item once the registered read has landed
  always @(negedge clk) begin
    if (sample_due) begin
      sb_item_t it;
      sample_due = 1'b0;
      it = sb_q.pop_front();
      checks++;
      if (rd_data !== it.exp) begin
        errors++;
        $display("FAIL %s actual %h expected %h", it.tag, rd_data, it.exp);
      end
    end
  end

  // driver: reads report the state at the calling negedge, take one cycle
  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    sb_item_t it;
    it.exp = exp;
    it.tag = tag;
    rd_addr = a;
    sb_q.push_back(it);
    @(posedge clk);
    sample_due = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    checks++;
    if (irq_o !== exp) begin
      errors++;
      $display("FAIL %s irq actual %b expected %b", tag, irq_o, exp);
    end
  endtask

  task automatic pulse(input logic active);
    pulse_in = active;
    repeat (3) @(negedge clk);
    pulse_in = ~active;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, 32'h0, "R1 ctrl");
    rd(2'd1, 32'h0, "R1 presc");
    rd(2'd2, 32'h0, "R1 cmp");
    rd(2'd3, 32'h0, "R1 count");
    chk_irq(1'b0, "R1");

    // R2 bypassed prescaler
    wr(2'd1, 32'h10);
    wr(2'd2, 32'hFFFF);
    wr(2'd0, 32'h01);
    repeat (5) @(negedge clk);
    rd(2'd3, 32'd5, "R2 count");
    wr(2'd0, 32'h00);
    @(negedge clk);
    rd(2'd3, 32'd0, "R10 count after stop");

    // R3 divide by 4
    wr(2'd1, 32'h01);
    wr(2'd0, 32'h01);
    repeat (11) @(negedge clk);
    rd(2'd3, 32'd2, "R3 count at 11");
    rd(2'd3, 32'd3, "R3 count at 12");
    wr(2'd0, 32'h00);
    @(negedge clk);

    // R6 / R9 compare reset
    wr(2'd1, 32'h10);
    wr(2'd2, 32'd3);
    wr(2'd0, 32'h11);
    repeat (3) @(negedge clk);
    chk_irq(1'b0, "R9 before match");
    rd(2'd3, 32'd3, "R6 count at compare");
    rd(2'd0, 32'h31, "R6 flag set");
    chk_irq(1'b1, "R9 after match");
    rd(2'd3, 32'd1, "R6 count restarted");
    wr(2'd0, 32'h10);
    @(negedge clk);
    rd(2'd0, 32'h10, "R10 flag cleared");
    rd(2'd3, 32'd0, "R10 count cleared");
    chk_irq(1'b0, "R9 after stop");

    // R7 free running
    wr(2'd0, 32'h08);
    wr(2'd0, 32'h09);
    repeat (4) @(negedge clk);
    rd(2'd3, 32'd4, "R7 passes compare");
    rd(2'd0, 32'h29, "R7 flag set");
    repeat (65529) @(negedge clk);
    rd(2'd3, 32'hFFFF, "R7 at max");
    rd(2'd3, 32'h0, "R7 wrapped");
    wr(2'd0, 32'h00);
    @(negedge clk);

    // R4 rising edges
    wr(2'd0, 32'h02);
    wr(2'd0, 32'h03);
    for (int i = 0; i < 3; i++) pulse(1'b1);
    repeat (4) @(negedge clk);
    rd(2'd3, 32'd3, "R4 rising count");
    wr(2'd0, 32'h00);
    @(negedge clk);

    // R5 falling edges, R12 read stability
    wr(2'd0, 32'h06);
    pulse_in = 1'b1;
    repeat (4) @(negedge clk);
    wr(2'd0, 32'h07);
    for (int i = 0; i < 2; i++) pulse(1'b0);
    repeat (4) @(negedge clk);
    rd(2'd3, 32'd2, "R5 falling count");
    rd(2'd3, 32'd2, "R12 second read");
    wr(2'd0, 32'h00);
    @(negedge clk);

    // R8 sticky flag, write-one-to-clear
    wr(2'd2, 32'd0);
    wr(2'd0, 32'h17);
    pulse(1'b0);
    repeat (4) @(negedge clk);
    rd(2'd0, 32'h37, "R8 flag set");
    chk_irq(1'b1, "R9 edge match");
    repeat (10) @(negedge clk);
    rd(2'd0, 32'h37, "R8 flag held");
    wr(2'd0, 32'h37);
    rd(2'd0, 32'h17, "R8 flag cleared");
    @(negedge clk);
    chk_irq(1'b0, "R9 after clear");

    // R11 locked configuration
    wr(2'd0, 32'h11);
    rd(2'd0, 32'h17, "R11 ctrl while running");
    wr(2'd1, 32'h05);
    rd(2'd1, 32'h10, "R11 presc while running");
    wr(2'd0, 32'h00);
    @(negedge clk);
    wr(2'd0, 32'h09);
    rd(2'd0, 32'h07, "R11 fields on enabling write");
    wr(2'd0, 32'h00);
    @(negedge clk);

    summary();
    $finish;
  end
endmodule